// File: doc/BRIEF.md
# Dipulse Line Transmit Encoder

This block turns a serial NRZ bit stream into drive for a dipulse line: two active-low outputs that feed an external line-coupling stage.

- Timing: the block runs from a 20 MHz clock at 2.5 Mbps, so each bit cell is 8 clocks (400 ns).
- A one: sent as a 100 ns low pulse on drive A, then a 100 ns low pulse on drive B. The two pulses never overlap.
- A zero: sent as silence on both outputs.

A user hands over one bit at a time with a request strobe and a data input. The block raises busy for the full cell it is sending. A request is taken when the block is idle, or in the last clock of a running cell. The second case lets a caller that holds the strobe high stream bits with no gap between cells.

Cell length and pulse length come from the clock rate, bit rate and pulse width parameters. Combinations that do not divide evenly, or that would let the pulses overlap, are rejected at elaboration. An option chooses between two output stages:
- registered drives (the default): the pulses are one clock later than the cell count;
- drives decoded straight from the cell state.

Top module: `dptx_encoder`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is 0 and both `drv_a_n` and `drv_b_n` are 1 until a request is taken.
- R2: A request seen on a rising edge while `busy` is 0 is taken. `busy` is 1 from the next clock for exactly 8 clocks, then returns to 0 if no further request is taken.
- R3: For a taken bit of value 1, `drv_a_n` is 0 for exactly 2 clocks. With the default registered output, those are cell clocks 1 and 2, counting from cell clock 0, the first clock with `busy` high.
- R4: For a taken bit of value 1, `drv_b_n` is 0 for the 2 clocks right after the `drv_a_n` pulse (cell clocks 3 and 4 with registered output). It is 1 for the rest of the cell.
- R5: `drv_a_n` and `drv_b_n` are never 0 in the same clock.
- R6: For a taken bit of value 0, both drives stay 1 for the whole cell.
- R7: A request during a cell, in any clock but the last, is ignored. The current cell keeps its length and pulses, and no extra cell follows.
- R8: A request in the last clock of a cell starts a new cell on the next clock, with `busy` held at 1. Back-to-back ones give one pulse pair every 8 clocks.
- R9: `tx_bit` is sampled only on the clock a request is taken. Later changes during the cell do not alter its pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Bit request strobe |
| tx_bit | input | 1 | NRZ bit value taken with the request |
| busy | output | 1 | High for every clock of a cell being sent |
| drv_a_n | output | 1 | First dipulse drive, active low |
| drv_b_n | output | 1 | Second dipulse drive, active low |

## Verification
The encoder is driven with four kinds of input:
- Isolated ones and isolated zeros from idle. These separate pulse placement and width from silence.
- A strobe held high for many cells with random data. This shows whether cells chain at the boundary with no gap.
- Strobes pulsed in the middle of a cell. These show whether a request taken too early would stretch or restart a cell.
- Data flipped after acceptance. This shows whether the bit is sampled once or followed live.

A behavioural model in the bench predicts `busy` and both drives on every clock.

// File: rtl/dptx_pkg.sv
package dptx_pkg;

   // clocks of one bit cell for a given clock and bit rate
   function automatic int cell_clocks(input int clk_hz, input int rate_bps);
      return clk_hz / rate_bps;
   endfunction

   // clocks covered by a pulse of width_ns at clk_hz (clk_hz a multiple of 1 MHz)
   function automatic int pulse_clocks(input int clk_hz, input int width_ns);
      return ((clk_hz / 1_000_000) * width_ns) / 1000;
   endfunction

   typedef struct packed {
      logic drv_a;
      logic drv_b;
   } dptx_drive_t;

endpackage

// File: rtl/dptx_cell_timer.sv
module dptx_cell_timer #(
   parameter int CELL_CLKS = 8,
   parameter int PHASE_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   output logic               take,
   output logic               active,
   output logic [PHASE_W-1:0] phase
);

   localparam logic [PHASE_W-1:0] LAST = PHASE_W'(CELL_CLKS - 1);

   logic at_last;

   assign at_last = active && (phase == LAST);
   assign take    = req && (!active || at_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
      end else if (take) begin
         active <= 1'b1;
         phase  <= '0;
      end else if (active) begin
         if (at_last) begin
            active <= 1'b0;
            phase  <= '0;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   // R2
   cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && phase != LAST) |=> active);

   // R7
   req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && phase != LAST) |=> (phase == $past(phase) + 1'b1));

   // R8
   boundary_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && phase == LAST && req) |=> (active && phase == '0));

   // R2
   idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && req) |=> (active && phase == '0));

endmodule

// File: rtl/dptx_bit_hold.sv
module dptx_bit_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic bit_in,
   output logic bit_val
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bit_val <= 1'b0;
      else if (take)
         bit_val <= bit_in;
   end

   // R9
   bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(bit_val));

endmodule

// File: rtl/dptx_pulse_shaper.sv
module dptx_pulse_shaper
   import dptx_pkg::*;
#(
   parameter int CELL_CLKS  = 8,
   parameter int PULSE_CLKS = 2,
   parameter int PHASE_W    = 3,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               bit_val,
   input  logic [PHASE_W-1:0] phase,
   output logic               drv_a_n,
   output logic               drv_b_n
);

   localparam int B_END = 2 * PULSE_CLKS;

   dptx_drive_t raw;
   logic        fire;
   int          ph;

   assign ph   = int'(phase);
   assign fire = active && bit_val;

   always_comb begin
      raw.drv_a = !(fire && (ph < PULSE_CLKS));
      raw.drv_b = !(fire && (ph >= PULSE_CLKS) && (ph < B_END));
   end

   generate
      if (OUT_REG) begin : g_reg
         dptx_drive_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '{drv_a: 1'b1, drv_b: 1'b1};
            else
               q <= raw;
         end
         assign drv_a_n = q.drv_a;
         assign drv_b_n = q.drv_b;
      end else begin : g_comb
         assign drv_a_n = raw.drv_a;
         assign drv_b_n = raw.drv_b;
      end
   endgenerate

   // R5
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!drv_a_n && !drv_b_n));

   // R6
   silent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_a_n || !drv_b_n) |-> bit_val);

   // R4
   b_follows_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_b_n) |-> $past(!drv_a_n));

endmodule

// File: rtl/dptx_encoder.sv
module dptx_encoder
   import dptx_pkg::*;
#(
   parameter int CLK_HZ   = 20_000_000,
   parameter int BIT_BPS  = 2_500_000,
   parameter int PULSE_NS = 100,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_req,
   input  logic tx_bit,
   output logic busy,
   output logic drv_a_n,
   output logic drv_b_n
);

   localparam int CELL_CLKS  = cell_clocks(CLK_HZ, BIT_BPS);
   localparam int PULSE_CLKS = pulse_clocks(CLK_HZ, PULSE_NS);
   localparam int PHASE_W    = (CELL_CLKS > 2) ? $clog2(CELL_CLKS) : 1;

   generate
      if (CLK_HZ % BIT_BPS != 0) begin : g_bad_rate
         $error("clock rate must be a whole multiple of the bit rate");
      end
      if (CLK_HZ % 1_000_000 != 0) begin : g_bad_clk
         $error("clock rate must be a whole number of MHz");
      end
      if (PULSE_CLKS < 1) begin : g_bad_pulse
         $error("pulse shorter than one clock");
      end
      if (2 * PULSE_CLKS > CELL_CLKS) begin : g_bad_fit
         $error("two pulses do not fit in one bit cell");
      end
   endgenerate

   logic               take;
   logic               active;
   logic               bit_val;
   logic [PHASE_W-1:0] phase;

   dptx_cell_timer #(
      .CELL_CLKS (CELL_CLKS),
      .PHASE_W   (PHASE_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (tx_req),
      .take   (take),
      .active (active),
      .phase  (phase)
   );

   dptx_bit_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .bit_in  (tx_bit),
      .bit_val (bit_val)
   );

   dptx_pulse_shaper #(
      .CELL_CLKS  (CELL_CLKS),
      .PULSE_CLKS (PULSE_CLKS),
      .PHASE_W    (PHASE_W),
      .OUT_REG    (OUT_REG)
   ) u_shaper (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .bit_val (bit_val),
      .phase   (phase),
      .drv_a_n (drv_a_n),
      .drv_b_n (drv_b_n)
   );

   assign busy = active;

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (drv_a_n && drv_b_n));

endmodule

// File: tb/dptx_encoder_bench.sv
`timescale 1ns/1ps
module dptx_encoder_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_req = 1'b0;
   logic tx_bit = 1'b0;
   logic busy, drv_a_n, drv_b_n;

   int total = 0;
   int bad = 0;
   bit cmp_on = 1'b0;
   string tag = "R1";

   // behavioural model: cell of 8 clocks, pulses of 2 clocks, registered drives
   int   m_act = 0;
   int   m_ph  = 0;
   int   m_bit = 0;
   logic ea = 1'b1;
   logic eb = 1'b1;

   always #2.5 clk = ~clk;

   dptx_encoder u_dptx_encoder (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_req  (tx_req),
      .tx_bit  (tx_bit),
      .busy    (busy),
      .drv_a_n (drv_a_n),
      .drv_b_n (drv_b_n)
   );

   function automatic logic model_a();
      return !(m_act != 0 && m_bit != 0 && m_ph < 2);
   endfunction

   function automatic logic model_b();
      return !(m_act != 0 && m_bit != 0 && m_ph >= 2 && m_ph < 4);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0; m_ph = 0; m_bit = 0; ea = 1'b1; eb = 1'b1;
      end else begin
         ea = model_a();
         eb = model_b();
         if (tx_req && (m_act == 0 || m_ph == 7)) begin
            m_act = 1; m_ph = 0; m_bit = tx_bit ? 1 : 0;
         end else if (m_act != 0) begin
            if (m_ph == 7) begin m_act = 0; m_ph = 0; end
            else m_ph = m_ph + 1;
         end
      end
   end

   task automatic check(input string r, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         check(tag, "busy", busy, (m_act != 0));
         check("R3", "drv_a_n", drv_a_n, ea);
         check("R4", "drv_b_n", drv_b_n, eb);
         check("R5", "overlap", !(!drv_a_n && !drv_b_n), 1'b1);
      end
   end

   task automatic send(input logic b);
      @(negedge clk);
      tx_req = 1'b1; tx_bit = b;
      @(negedge clk);
      tx_req = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
   end

   initial begin
      int cnt;
      int lows;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", busy, 1'b0);
      check("R1", "drv_a_n in reset", drv_a_n, 1'b1);
      check("R1", "drv_b_n in reset", drv_b_n, 1'b1);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(4);
      check("R1", "busy idle", busy, 1'b0);

      // R2 + R3: isolated one, busy length and pulse count
      tag = "R2";
      send(1'b1);
      cnt = 1; lows = (drv_a_n == 1'b0) ? 1 : 0;
      while (busy) begin
         @(negedge clk);
         if (busy) cnt++;
         if (!drv_a_n) lows++;
      end
      check("R2", "busy length is 8", (cnt == 8), 1'b1);
      check("R3", "drv_a_n low for 2 clocks", (lows == 2), 1'b1);
      idle(4);

      // R6: isolated zero gives silence
      tag = "R6";
      send(1'b0);
      cnt = 0;
      for (int i = 0; i < 10; i++) begin
         if (!drv_a_n || !drv_b_n) cnt++;
         @(negedge clk);
      end
      check("R6", "zero cell silent", (cnt == 0), 1'b1);
      idle(3);

      // R7: mid-cell request ignored, no extra cell
      tag = "R7";
      send(1'b1);
      idle(2);
      send(1'b1);
      cnt = 0;
      for (int i = 0; i < 14; i++) begin
         if (busy) cnt++;
         @(negedge clk);
      end
      check("R7", "no extra cell after mid-cell request", (cnt <= 5), 1'b1);
      idle(3);

      // R9: data changes after acceptance
      tag = "R9";
      @(negedge clk);
      tx_req = 1'b1; tx_bit = 1'b0;
      @(negedge clk);
      tx_req = 1'b0; tx_bit = 1'b1;
      lows = 0;
      for (int i = 0; i < 9; i++) begin
         if (!drv_a_n || !drv_b_n) lows++;
         @(negedge clk);
      end
      check("R9", "late data change ignored", (lows == 0), 1'b1);
      tx_bit = 1'b0;
      idle(3);

      // R8: strobe held high, chained cells with random data
      tag = "R8";
      @(negedge clk);
      tx_req = 1'b1;
      for (int i = 0; i < 8 * 40; i++) begin
         tx_bit = (i < 24) ? 1'b1 : 1'($urandom_range(0, 1));
         @(negedge clk);
         if (i > 0) check("R8", "busy stays high while chaining", busy, 1'b1);
      end
      tx_req = 1'b0;
      idle(12);

      // mixed pattern: sparse requests with random data and gaps
      tag = "R2";
      for (int i = 0; i < 60; i++) begin
         send(1'($urandom_range(0, 1)));
         idle(int'($urandom_range(0, 10)));
      end
      idle(12);

      summary();
      $finish;
   end

endmodule